// File: doc/BRIEF.md
# Streaming 512-Byte Hamming ECC Generator and Corrector

This block computes a single-error-correcting, double-error-detecting Hamming code over a block of data bytes as they pass through it. Each byte carries twelve address bits: nine for its position in the block and three for each bit's place in the byte. For every address bit the block keeps two parities. One covers the data bits whose address has that bit set. The other covers the data bits whose address has it clear. The two 12-bit parity sets form a 24-bit code. The code is inverted so that a freshly erased block, all bytes 0xFF, matches a stored code of all ones.

Several independent contexts exist, one per chip select. A select input routes the byte stream, the check request and the code output to one context. A per-context restart pulse empties that context. On readback, the stored 24-bit code is presented with a check pulse. The block compares it with the code it has accumulated and returns a registered verdict. For a correctable data error it also returns the byte and bit to flip. The check also empties the context, so the next block starts clean. The data buffer lives outside this block.

Top module: `hamming_blk_ecc`

## Requirements
- R1: A context accepts at most BLOCK_BYTES bytes (default 512). `block_full` is high once it holds that many. Further valid bytes leave the code unchanged.
- R2: `code_out[12+k]` is the inverted XOR of all data bits whose 12-bit address {byte index, bit index} has bit k set. `code_out[k]` is the inverted XOR of the bits whose address bit k is clear. The bit index is the low three address bits.
- R3: An empty context, including the state after reset, gives code 0xFFFFFF. A full block of 0xFF bytes also gives 0xFFFFFF.
- R4: With diff = check_code XOR computed code, diff of zero yields verdict 0 (clean).
- R5: If diff[11:0] XOR diff[23:12] equals 0xFFF, the verdict is 1 (data fix). `res_byte` is diff[23:15] and `res_bit` is diff[14:12].
- R6: A result that qualifies under R5 but whose byte index is BLOCK_BYTES or more yields verdict 3.
- R7: A diff with exactly one bit set yields verdict 2 (code bytes only). Whenever the verdict is not 1, `res_byte` and `res_bit` are zero.
- R8: Any other nonzero diff yields verdict 3 (uncorrectable).
- R9: `res_valid` is high for exactly the one cycle after each cycle in which `check_valid` is high.
- R10: A check empties the selected context at the same edge. A byte presented in that same cycle is dropped.
- R11: `restart[i]` empties context i only. It takes priority over a byte for context i in the same cycle, and other contexts keep their state.
- R12: `cs_sel` picks the context that takes bytes, serves the check and drives `code_out` and `block_full`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_sel | input | CS_W | Context select |
| restart | input | NUM_CS | Per-context restart pulses |
| byte_valid | input | 1 | Data byte present |
| byte_data | input | 8 | Data byte |
| check_valid | input | 1 | Check request; empties the selected context |
| check_code | input | 24 | Stored code to compare |
| code_out | output | 24 | Inverted packed code of the selected context |
| block_full | output | 1 | Selected context holds BLOCK_BYTES bytes |
| res_valid | output | 1 | Result pulse |
| res_verdict | output | 2 | 0 clean, 1 data fix, 2 code only, 3 uncorrectable |
| res_byte | output | 9 | Byte index to fix |
| res_bit | output | 3 | Bit index to fix |

## Verification
The bench aims at these corner cases:
- An erased block and an empty context. A design that inverted the code wrongly or packed the fields wrongly would report an error where none exists.
- Bytes offered after a block is full. A design that kept accumulating them would wrap the byte index and corrupt the code.
- A correctable flip at a known byte and bit, a single flipped code bit and a two-bit diff. Each is checked for the right verdict and indices. A second instance with a 256-byte block checks that an out-of-range correctable index is demoted to uncorrectable.
- Restart and check pulses that collide with a byte in the same cycle, with other contexts holding data. A design with the wrong priority, or one that clears the wrong context, shows a code mismatch on the untouched context.

// File: rtl/ecc_hm_pkg.sv
package ecc_hm_pkg;

  localparam int COL_BITS = 3;
  localparam int ROW_BITS = 9;
  localparam int FIELD_W  = COL_BITS + ROW_BITS;
  localparam int GAP_W    = 4;
  localparam int RAW_W    = 2 * FIELD_W + GAP_W;
  localparam int CODE_W   = 2 * FIELD_W;

  typedef enum logic [1:0] {
    VERDICT_CLEAN     = 2'd0,
    VERDICT_DATA_FIX  = 2'd1,
    VERDICT_CODE_ONLY = 2'd2,
    VERDICT_FATAL     = 2'd3
  } ecc_verdict_e;

  // Bits of a byte whose in-byte index has bit k set
  function automatic logic [7:0] col_mask(input int k);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> k) & 1) == 1;
    return m;
  endfunction

  // Raw layout: set-parities at [27:16], clear-parities at [11:0]
  function automatic logic [CODE_W-1:0] pack_code(input logic [RAW_W-1:0] raw);
    return ~{raw[RAW_W-1 -: FIELD_W], raw[FIELD_W-1:0]};
  endfunction

endpackage

// File: rtl/ecc_hm_contrib.sv
module ecc_hm_contrib
  import ecc_hm_pkg::*;
(
  input  logic [7:0]          data,
  input  logic [ROW_BITS-1:0] idx,
  output logic [RAW_W-1:0]    mask
);

  logic                row_par;
  logic [FIELD_W-1:0]  set_f;
  logic [FIELD_W-1:0]  clr_f;

  assign row_par = ^data;

  for (genvar k = 0; k < COL_BITS; k++) begin : g_col
    localparam logic [7:0] SEL = col_mask(k);
    assign set_f[k] = ^(data & SEL);
    assign clr_f[k] = ^(data & ~SEL);
  end

  for (genvar j = 0; j < ROW_BITS; j++) begin : g_row
    assign set_f[COL_BITS+j] = idx[j] & row_par;
    assign clr_f[COL_BITS+j] = ~idx[j] & row_par;
  end

  assign mask = {set_f, {GAP_W{1'b0}}, clr_f};

endmodule

// File: rtl/ecc_hm_context.sv
module ecc_hm_context
  import ecc_hm_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int CNT_W       = $clog2(BLOCK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [7:0]       data,
  output logic [RAW_W-1:0] raw,
  output logic             full
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BLOCK_BYTES);

  logic [RAW_W-1:0] raw_q, raw_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RAW_W-1:0] contrib;
  logic [ROW_BITS-1:0] idx;

  assign idx  = ROW_BITS'(cnt_q);
  assign full = (cnt_q == LIMIT);
  assign raw  = raw_q;

  ecc_hm_contrib u_contrib (
    .data (data),
    .idx  (idx),
    .mask (contrib)
  );

  always_comb begin
    raw_d = raw_q;
    cnt_d = cnt_q;
    if (clr) begin
      raw_d = '0;
      cnt_d = '0;
    end else if (take && !full) begin
      raw_d = raw_q ^ contrib;
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      cnt_q <= '0;
    end else begin
      raw_q <= raw_d;
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);  // R1
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full && !clr |=> $stable(raw_q));  // R1
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && (raw_q == '0));  // R10

endmodule

// File: rtl/ecc_hm_classify.sv
module ecc_hm_classify
  import ecc_hm_pkg::*;
#(
  parameter int BLOCK_BYTES = 512
) (
  input  logic [CODE_W-1:0]   stored,
  input  logic [CODE_W-1:0]   calc,
  output ecc_verdict_e        verdict,
  output logic [ROW_BITS-1:0] fix_byte,
  output logic [COL_BITS-1:0] fix_bit
);

  localparam logic [31:0] LIM = 32'(BLOCK_BYTES);

  logic [CODE_W-1:0]   diff;
  logic                halves_compl;
  logic                one_hot;
  logic [ROW_BITS-1:0] d_byte;
  logic [COL_BITS-1:0] d_bit;

  assign diff         = stored ^ calc;
  assign halves_compl = (diff[FIELD_W-1:0] ^ diff[CODE_W-1:FIELD_W]) == {FIELD_W{1'b1}};
  assign one_hot      = $onehot(diff);
  assign d_byte       = diff[CODE_W-1 -: ROW_BITS];
  assign d_bit        = diff[FIELD_W +: COL_BITS];

  always_comb begin
    verdict  = VERDICT_FATAL;
    fix_byte = '0;
    fix_bit  = '0;
    if (diff == '0) begin
      verdict = VERDICT_CLEAN;
    end else if (halves_compl) begin
      if (32'(d_byte) < LIM) begin
        verdict  = VERDICT_DATA_FIX;
        fix_byte = d_byte;
        fix_bit  = d_bit;
      end
    end else if (one_hot) begin
      verdict = VERDICT_CODE_ONLY;
    end
  end

endmodule

// File: rtl/hamming_blk_ecc.sv
module hamming_blk_ecc
  import ecc_hm_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int NUM_CS      = 4,
  parameter int CS_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic [NUM_CS-1:0] restart,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              check_valid,
  input  logic [23:0]       check_code,
  output logic [23:0]       code_out,
  output logic              block_full,
  output logic              res_valid,
  output logic [1:0]        res_verdict,
  output logic [8:0]        res_byte,
  output logic [2:0]        res_bit
);

  localparam logic [31:0] LIM = 32'(BLOCK_BYTES);

  logic [RAW_W-1:0] ctx_raw  [NUM_CS];
  logic             ctx_full [NUM_CS];
  logic [RAW_W-1:0] sel_raw;
  logic             sel_full;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_ctx
    logic hit;
    assign hit = (cs_sel == CS_W'(i));
    ecc_hm_context #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctx (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart[i] | (check_valid & hit)),
      .take  (byte_valid & hit & ~check_valid),
      .data  (byte_data),
      .raw   (ctx_raw[i]),
      .full  (ctx_full[i])
    );
  end

  if (NUM_CS == 1) begin : g_sel_single
    assign sel_raw  = ctx_raw[0];
    assign sel_full = ctx_full[0];
  end else begin : g_sel_multi
    assign sel_raw  = ctx_raw[cs_sel];
    assign sel_full = ctx_full[cs_sel];
  end

  assign code_out   = pack_code(sel_raw);
  assign block_full = sel_full;

  ecc_verdict_e        cls_verdict;
  logic [ROW_BITS-1:0] cls_byte;
  logic [COL_BITS-1:0] cls_bit;

  ecc_hm_classify #(.BLOCK_BYTES(BLOCK_BYTES)) u_cls (
    .stored   (check_code),
    .calc     (code_out),
    .verdict  (cls_verdict),
    .fix_byte (cls_byte),
    .fix_bit  (cls_bit)
  );

  logic       rv_q, rv_d;
  logic [1:0] vd_q, vd_d;
  logic [8:0] rb_q, rb_d;
  logic [2:0] rt_q, rt_d;

  always_comb begin
    rv_d = check_valid;
    vd_d = vd_q;
    rb_d = rb_q;
    rt_d = rt_q;
    if (check_valid) begin
      vd_d = cls_verdict;
      rb_d = cls_byte;
      rt_d = cls_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      vd_q <= '0;
      rb_q <= '0;
      rt_q <= '0;
    end else begin
      rv_q <= rv_d;
      vd_q <= vd_d;
      rb_q <= rb_d;
      rt_q <= rt_d;
    end
  end

  assign res_valid   = rv_q;
  assign res_verdict = vd_q;
  assign res_byte    = rb_q;
  assign res_bit     = rt_q;

  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    check_valid |=> res_valid);  // R9
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !check_valid |=> !res_valid);  // R9
  AST_FIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_verdict == 2'd1) |-> (32'(res_byte) < LIM));  // R6
  AST_NOFIX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_verdict != 2'd1) |-> (res_byte == '0) && (res_bit == '0));  // R7

endmodule

// File: tb/tb_hamming_blk_ecc.sv
module tb_hamming_blk_ecc;

  localparam int NB  = 512;
  localparam int NCS = 4;
  localparam int SNB = 256;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [1:0]  cs_sel;
  logic [3:0]  restart;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        check_valid;
  logic [23:0] check_code;
  logic [23:0] code_out;
  logic        block_full;
  logic        res_valid;
  logic [1:0]  res_verdict;
  logic [8:0]  res_byte;
  logic [2:0]  res_bit;

  logic        s_check_valid;
  logic [23:0] s_check_code;
  logic [23:0] s_code_out;
  logic        s_block_full;
  logic        s_res_valid;
  logic [1:0]  s_res_verdict;
  logic [8:0]  s_res_byte;
  logic [2:0]  s_res_bit;

  hamming_blk_ecc #(.BLOCK_BYTES(NB), .NUM_CS(NCS)) dut (
    .clk(clk), .rst_n(rst_n), .cs_sel(cs_sel), .restart(restart),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .check_valid(check_valid), .check_code(check_code),
    .code_out(code_out), .block_full(block_full), .res_valid(res_valid),
    .res_verdict(res_verdict), .res_byte(res_byte), .res_bit(res_bit)
  );

  hamming_blk_ecc #(.BLOCK_BYTES(SNB), .NUM_CS(1)) dut_small (
    .clk(clk), .rst_n(rst_n), .cs_sel(1'b0), .restart(1'b0),
    .byte_valid(1'b0), .byte_data(8'h00),
    .check_valid(s_check_valid), .check_code(s_check_code),
    .code_out(s_code_out), .block_full(s_block_full), .res_valid(s_res_valid),
    .res_verdict(s_res_verdict), .res_byte(s_res_byte), .res_bit(s_res_bit)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Behavioural reference state
  int          m_cnt [NCS];
  logic [11:0] m_set [NCS];
  logic [11:0] m_clr [NCS];
  logic        e_rv;
  logic [1:0]  e_vd;
  logic [8:0]  e_rb;
  logic [2:0]  e_rt;

  function automatic logic [23:0] mcode(input int c);
    return ~{m_set[c], m_clr[c]};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic m_add(input int c, input logic [7:0] d);
    if (m_cnt[c] < NB) begin
      for (int b = 0; b < 8; b++) begin
        if (d[b]) begin
          int addr = m_cnt[c] * 8 + b;
          for (int k = 0; k < 12; k++) begin
            if ((addr >> k) & 1) m_set[c][k] = ~m_set[c][k];
            else                 m_clr[c][k] = ~m_clr[c][k];
          end
        end
      end
      m_cnt[c]++;
    end
  endtask

  task automatic m_classify(input logic [23:0] d, input int lim,
                            output logic [1:0] v, output logic [8:0] by,
                            output logic [2:0] bt);
    v = 2'd3; by = '0; bt = '0;
    if (d == 24'h0) v = 2'd0;
    else if (((d ^ (d >> 12)) & 24'hFFF) == 24'hFFF) begin
      if (int'(d >> 15) < lim) begin
        v = 2'd1; by = d[23:15]; bt = d[14:12];
      end
    end else if ($countones(d) == 1) v = 2'd2;
  endtask

  function automatic string vtag(input logic [1:0] v);
    case (v)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    e_rv = check_valid;
    if (check_valid)
      m_classify(check_code ^ mcode(int'(cs_sel)), NB, e_vd, e_rb, e_rt);
    for (int c = 0; c < NCS; c++) begin
      if (restart[c] || (check_valid && int'(cs_sel) == c)) begin
        m_cnt[c] = 0; m_set[c] = '0; m_clr[c] = '0;
      end else if (byte_valid && !check_valid && int'(cs_sel) == c) begin
        m_add(c, byte_data);
      end
    end
    @(negedge clk);
    check("R2", "code_out", 32'(code_out), 32'(mcode(int'(cs_sel))));
    check("R1", "block_full", 32'(block_full), 32'(m_cnt[int'(cs_sel)] == NB));
    check("R9", "res_valid", 32'(res_valid), 32'(e_rv));
    if (e_rv) begin
      check(vtag(e_vd), "res_verdict", 32'(res_verdict), 32'(e_vd));
      check(vtag(e_vd), "res_byte", 32'(res_byte), 32'(e_rb));
      check(vtag(e_vd), "res_bit", 32'(res_bit), 32'(e_rt));
    end
  endtask

  task automatic send(input int c, input logic [7:0] d);
    cs_sel = 2'(c); byte_valid = 1'b1; byte_data = d;
    step();
    byte_valid = 1'b0;
  endtask

  task automatic do_check(input int c, input logic [23:0] code);
    cs_sel = 2'(c); check_valid = 1'b1; check_code = code;
    step();
    check_valid = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic stream_pat(input int c);
    for (int i = 0; i < NB; i++) send(c, pat(i));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int t = 0; t < 100000; t++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    logic [23:0] c1, flip, saved3;
    int a;
    rst_n = 1'b0; cs_sel = '0; restart = '0; byte_valid = 1'b0; byte_data = '0;
    check_valid = 1'b0; check_code = '0; s_check_valid = 1'b0; s_check_code = '0;
    for (int c = 0; c < NCS; c++) begin m_cnt[c] = 0; m_set[c] = '0; m_clr[c] = '0; end
    e_rv = 1'b0; e_vd = '0; e_rb = '0; e_rt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R3", "reset code", 32'(code_out), 32'h00FFFFFF);
    check("R9", "reset res_valid", 32'(res_valid), 32'h0);
    check("R1", "reset block_full", 32'(block_full), 32'h0);

    // Erased block
    for (int i = 0; i < NB; i++) send(0, 8'hFF);
    check("R3", "erased code", 32'(code_out), 32'h00FFFFFF);
    check("R1", "full after block", 32'(block_full), 32'h1);
    // Extra bytes ignored
    send(0, 8'h5A); send(0, 8'h01); send(0, 8'h80);
    check("R1", "code after overflow bytes", 32'(code_out), 32'h00FFFFFF);
    do_check(0, 24'hFFFFFF);
    check("R4", "erased verdict", 32'(res_verdict), 32'h0);
    check("R10", "cleared after check", 32'(block_full), 32'h0);

    // Correctable data flip: byte 100 bit 5
    stream_pat(1);
    c1 = mcode(1);
    a = 100 * 8 + 5;
    flip = {12'(a), ~12'(a)};
    do_check(1, c1 ^ flip);
    check("R5", "fix verdict", 32'(res_verdict), 32'h1);
    check("R5", "fix byte", 32'(res_byte), 32'd100);
    check("R5", "fix bit", 32'(res_bit), 32'd5);

    // Single code bit wrong
    stream_pat(1);
    do_check(1, c1 ^ 24'h000080);
    check("R7", "code-only verdict", 32'(res_verdict), 32'h2);
    check("R7", "code-only byte zero", 32'(res_byte), 32'h0);

    // Two-bit diff
    stream_pat(1);
    do_check(1, c1 ^ 24'h000003);
    check("R8", "double verdict", 32'(res_verdict), 32'h3);

    // Out-of-range correctable index on a 256-byte instance; byte 300 bit 2
    a = 300 * 8 + 2;
    flip = {12'(a), ~12'(a)};
    s_check_valid = 1'b1; s_check_code = 24'hFFFFFF ^ flip;
    cs_sel = 2'd0;
    step();
    s_check_valid = 1'b0;
    check("R6", "small verdict", 32'(s_res_verdict), 32'h3);
    check("R6", "small byte zero", 32'(s_res_byte), 32'h0);
    check("R9", "small res_valid", 32'(s_res_valid), 32'h1);
    do_check(0, 24'hFFFFFF ^ flip);
    check("R5", "same diff in range on full size", 32'(res_verdict), 32'h1);
    check("R5", "in range byte", 32'(res_byte), 32'd300);

    // Restart isolation
    for (int i = 0; i < 10; i++) send(2, pat(i + 3));
    for (int i = 0; i < 10; i++) send(3, pat(i + 50));
    saved3 = mcode(3);
    cs_sel = 2'd2; restart = 4'b0100; byte_valid = 1'b1; byte_data = 8'hC3;
    step();
    restart = '0; byte_valid = 1'b0;
    check("R11", "restarted ctx empty", 32'(code_out), 32'h00FFFFFF);
    cs_sel = 2'd3;
    step();
    check("R11", "other ctx kept", 32'(code_out), 32'(saved3));

    // Select routing: one bit at address 0 into ctx 2
    send(2, 8'h01);
    check("R12", "ctx2 code", 32'(code_out), 32'h00FFF000);
    cs_sel = 2'd3;
    step();
    check("R12", "ctx3 untouched", 32'(code_out), 32'(saved3));

    // Check colliding with a byte
    for (int i = 0; i < 5; i++) send(0, pat(i + 7));
    cs_sel = 2'd0; check_valid = 1'b1; check_code = mcode(0);
    byte_valid = 1'b1; byte_data = 8'hA5;
    step();
    check_valid = 1'b0; byte_valid = 1'b0;
    check("R10", "collide verdict", 32'(res_verdict), 32'h0);
    check("R10", "byte dropped", 32'(code_out), 32'h00FFFFFF);

    // Partial block round trip on ctx 3
    for (int i = 0; i < 200; i++) send(3, pat(i * 3));
    do_check(3, mcode(3));
    check("R4", "partial clean", 32'(res_verdict), 32'h0);
    step();
    check("R9", "pulse drops", 32'(res_valid), 32'h0);

    finish_run();
  end

endmodule